// File: doc/BRIEF.md
# Machine-check error status logger

This block keeps one 64-bit error status word for a hardware error reporting bank. Error reports arrive as single-cycle strobes. Each report carries a severity bit (uncorrected or corrected), a 3-bit error type and a 16-bit error code. The error type picks one bit of an 8-bit enable mask, and that bit is stored as the enabled flag of the report.

An empty word takes any report. When the word already holds a valid report, a fixed priority decides whether the new report replaces it. The overflow flag is raised on every such collision, whether or not the new report is kept.

Software reads the word at any time. Software clears the word by writing zero to it. A write of any other value does nothing.

Top module: `mcl_status_logger`

## Requirements
- R1: After reset the status word reads all zeros.
- R2: A report that arrives while the valid flag (bit 63) is 0 is captured one cycle later. The captured word has bit 63 = 1, bit 62 (overflow) = 0, bit 61 = the severity (1 uncorrected, 0 corrected), bit 60 = the enabled flag, bits 15:0 = the code, and bits 59:16 = 0.
- R3: A report that arrives while bit 63 is 1 sets bit 62 to 1, whether or not it replaces the logged report. Bit 62 then stays at 1 until software clears the word.
- R4: A corrected, enabled report replaces a logged corrected, disabled report.
- R5: An uncorrected report replaces a logged corrected report, whatever the enable state of either report.
- R6: An uncorrected report never replaces a logged uncorrected report. Bits 61:0 other than overflow are left unchanged.
- R7: When both reports are corrected and have the same enable state, the logged report is kept. A corrected report never replaces a logged uncorrected report.
- R8: The enabled flag (bit 60) of a captured report equals bit `type` of the enable mask at the capture cycle.
- R9: A software write of value zero clears all 64 bits, visible in the next cycle. A software write of any non-zero value leaves the word unchanged.
- R10: When a report arrives in the same cycle as a zero write, the report is captured as a fresh entry: valid = 1 and overflow = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Error report strobe |
| evt_uncorr | input | 1 | Report severity: 1 uncorrected, 0 corrected |
| evt_type | input | 3 | Error type index into the enable mask |
| evt_code | input | 16 | Error code of the report |
| enable_mask | input | 8 | Per-type enable bits |
| sw_wr | input | 1 | Software write strobe to the status word |
| sw_wdata | input | 64 | Software write data; only zero clears |
| status | output | 64 | Current status word |

## Verification
A software clear and an incoming error report can fall in the same cycle. The expected result is then a freshly captured entry with the overflow flag at zero, not an empty word and not an overflowed one. The bench drives both strobes on one edge, once with a valid uncorrected entry logged beforehand. A scoreboard model computes the expected word from the requirements, and the model's result is compared with the design's output one cycle later.

// File: rtl/mcl_pkg.sv
package mcl_pkg;
  localparam int VALID_BIT = 63;
  localparam int OVER_BIT  = 62;
  localparam int UC_BIT    = 61;
  localparam int EN_BIT    = 60;

  // Replacement priority: severity first, then enable state; ties keep the logged entry.
  function automatic logic take_new(input logic log_valid, input logic log_uc,
                                    input logic log_en, input logic new_uc,
                                    input logic new_en);
    if (!log_valid)   return 1'b1;
    else if (log_uc)  return 1'b0;
    else if (new_uc)  return 1'b1;
    else              return new_en & ~log_en;
  endfunction

  function automatic logic is_clear(input logic wr, input logic [63:0] data);
    return wr && (data == 64'd0);
  endfunction
endpackage

// File: rtl/mcl_enable_select.sv
module mcl_enable_select #(
  parameter int TYPE_W = 3,
  localparam int MASK_W = 1 << TYPE_W
) (
  input  logic [MASK_W-1:0] mask,
  input  logic [TYPE_W-1:0] type_idx,
  output logic              en
);
  assign en = mask[type_idx];
endmodule

// File: rtl/mcl_replace_arbiter.sv
module mcl_replace_arbiter (
  input  logic evt,
  input  logic clear,
  input  logic log_valid,
  input  logic log_uc,
  input  logic log_en,
  input  logic new_uc,
  input  logic new_en,
  output logic capture,
  output logic set_over
);
  import mcl_pkg::*;

  logic base_valid;
  logic base_uc;
  logic base_en;

  // A same-cycle clear makes the arbiter see an empty register.
  assign base_valid = log_valid & ~clear;
  assign base_uc    = log_uc    & ~clear;
  assign base_en    = log_en    & ~clear;

  assign capture  = evt & take_new(base_valid, base_uc, base_en, new_uc, new_en);
  assign set_over = evt & base_valid;

  always_comb begin
    if (set_over && log_uc && new_uc)
      assert_uc_no_replace_R6: assert (!capture);
  end
endmodule

// File: rtl/mcl_status_reg.sv
module mcl_status_reg #(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              evt,
  input  logic              capture,
  input  logic              set_over,
  input  logic              new_uc,
  input  logic              new_en,
  input  logic [CODE_W-1:0] new_code,
  output logic              valid_q,
  output logic              over_q,
  output logic              uc_q,
  output logic              en_q,
  output logic [CODE_W-1:0] code_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      over_q  <= 1'b0;
      uc_q    <= 1'b0;
      en_q    <= 1'b0;
      code_q  <= '0;
    end else begin
      if (capture) begin
        valid_q <= 1'b1;
        uc_q    <= new_uc;
        en_q    <= new_en;
        code_q  <= new_code;
      end else if (clear) begin
        valid_q <= 1'b0;
        uc_q    <= 1'b0;
        en_q    <= 1'b0;
        code_q  <= '0;
      end
      over_q <= (over_q & ~clear) | set_over;
    end
  end

  assert_overflow_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt && valid_q && !clear |=> over_q);

  assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    over_q && !clear |=> over_q);

  assert_empty_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt && !valid_q && !clear |=> valid_q && !over_q && code_q == $past(new_code));

  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear && !evt |=> !valid_q && !over_q && !uc_q && !en_q && code_q == '0);

  assert_clear_event_fresh_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear && evt |=> valid_q && !over_q);

  assert_uc_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt && valid_q && uc_q && !clear |=> uc_q && $stable(code_q));
endmodule

// File: rtl/mcl_status_logger.sv
module mcl_status_logger #(
  parameter int TYPE_W   = 3,
  parameter int CODE_W   = 16,
  parameter int STATUS_W = 64,
  localparam int MASK_W  = 1 << TYPE_W,
  localparam int PAD_W   = STATUS_W - 4 - CODE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evt_valid,
  input  logic                evt_uncorr,
  input  logic [TYPE_W-1:0]   evt_type,
  input  logic [CODE_W-1:0]   evt_code,
  input  logic [MASK_W-1:0]   enable_mask,
  input  logic                sw_wr,
  input  logic [STATUS_W-1:0] sw_wdata,
  output logic [STATUS_W-1:0] status
);
  import mcl_pkg::*;

  logic              clear;
  logic              new_en;
  logic              capture;
  logic              set_over;
  logic              valid_q;
  logic              over_q;
  logic              uc_q;
  logic              en_q;
  logic [CODE_W-1:0] code_q;

  assign clear = is_clear(sw_wr, 64'(sw_wdata));

  mcl_enable_select #(.TYPE_W(TYPE_W)) u_en_sel (
    .mask     (enable_mask),
    .type_idx (evt_type),
    .en       (new_en)
  );

  mcl_replace_arbiter u_arb (
    .evt       (evt_valid),
    .clear     (clear),
    .log_valid (valid_q),
    .log_uc    (uc_q),
    .log_en    (en_q),
    .new_uc    (evt_uncorr),
    .new_en    (new_en),
    .capture   (capture),
    .set_over  (set_over)
  );

  mcl_status_reg #(.CODE_W(CODE_W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .evt      (evt_valid),
    .capture  (capture),
    .set_over (set_over),
    .new_uc   (evt_uncorr),
    .new_en   (new_en),
    .new_code (evt_code),
    .valid_q  (valid_q),
    .over_q   (over_q),
    .uc_q     (uc_q),
    .en_q     (en_q),
    .code_q   (code_q)
  );

  assign status = {valid_q, over_q, uc_q, en_q, {PAD_W{1'b0}}, code_q};

  assert_enable_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> status[EN_BIT] == $past(enable_mask[evt_type]));

  assert_uc_replaces_corr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !clear && valid_q && !uc_q && evt_uncorr |=> status[UC_BIT]);

  assert_no_corr_over_uc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !clear && valid_q && uc_q && !evt_uncorr |=> status[UC_BIT] && $stable(code_q));

  assert_en_replaces_dis_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !clear && valid_q && !uc_q && !en_q && !evt_uncorr && new_en
    |=> status[EN_BIT] && status[CODE_W-1:0] == $past(evt_code));
endmodule

// File: tb/mcl_status_logger_bench.sv
`timescale 1ns/1ps
module mcl_status_logger_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic        evt_uncorr = 1'b0;
  logic [2:0]  evt_type = '0;
  logic [15:0] evt_code = '0;
  logic [7:0]  enable_mask = '0;
  logic        sw_wr = 1'b0;
  logic [63:0] sw_wdata = '0;
  logic [63:0] status;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] exp;
    string       req;
  } sb_item_t;

  sb_item_t    sb_q[$];
  logic [63:0] model_word = '0;

  always #2 clk = ~clk;

  mcl_status_logger u_mcl_status_logger (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_uncorr(evt_uncorr),
    .evt_type(evt_type), .evt_code(evt_code), .enable_mask(enable_mask),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata), .status(status)
  );

  // Reference model written from the requirements.
  function automatic logic [63:0] predict(input logic [63:0] cur, input logic ev,
      input logic uc, input logic [2:0] typ, input logic [15:0] code,
      input logic [7:0] mask, input logic wr, input logic [63:0] wd);
    logic [63:0] base;
    logic [63:0] fresh;
    logic        keep_new;
    base = (wr && wd == 64'd0) ? 64'd0 : cur;
    if (!ev) return base;
    fresh = {1'b1, 1'b0, uc, mask[typ], 44'd0, code};
    if (!base[63]) return fresh;
    case ({base[61], uc})
      2'b10, 2'b11: keep_new = 1'b0;
      2'b01:        keep_new = 1'b1;
      default:      keep_new = mask[typ] && !base[60];
    endcase
    base = keep_new ? fresh : base;
    base[62] = 1'b1;
    return base;
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: status=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic ev, input logic uc, input logic [2:0] typ,
      input logic [15:0] code, input logic [7:0] mask, input logic wr,
      input logic [63:0] wd, input string req);
    sb_item_t it;
    @(negedge clk);
    evt_valid = ev; evt_uncorr = uc; evt_type = typ; evt_code = code;
    enable_mask = mask; sw_wr = wr; sw_wdata = wd;
    model_word = predict(model_word, ev, uc, typ, code, mask, wr, wd);
    it.exp = model_word;
    it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Monitor: compares one expected item after every clock edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        check(status, it.exp, it.req);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, status=%h expected=done", status);
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    check(status, 64'd0, "R1 reset");
    // corrected, type 2 disabled
    step(1, 0, 3'd2, 16'h1111, 8'h00, 0, 64'd0, "R2 R8 empty capture disabled");
    // corrected enabled replaces disabled, overflow set
    step(1, 0, 3'd1, 16'h2222, 8'h02, 0, 64'd0, "R4 R3 enabled over disabled");
    step(1, 0, 3'd1, 16'h3333, 8'h00, 0, 64'd0, "R7 disabled vs enabled kept");
    step(1, 0, 3'd4, 16'h4444, 8'h10, 0, 64'd0, "R7 tie kept");
    step(1, 1, 3'd3, 16'h5555, 8'h00, 0, 64'd0, "R5 uc over corrected");
    step(1, 1, 3'd3, 16'h6666, 8'hFF, 0, 64'd0, "R6 uc not over uc");
    step(1, 0, 3'd0, 16'h7777, 8'h01, 0, 64'd0, "R7 corrected not over uc");
    step(0, 0, 3'd0, 16'h0000, 8'h00, 1, 64'h0000_0001_0000_0000, "R9 nonzero write ignored");
    step(0, 0, 3'd0, 16'h0000, 8'h00, 0, 64'd0, "R3 overflow sticky");
    step(0, 0, 3'd0, 16'h0000, 8'h00, 1, 64'd0, "R9 zero write clears");
    step(1, 1, 3'd7, 16'h8888, 8'h80, 0, 64'd0, "R2 R8 empty capture uc enabled");
    step(1, 0, 3'd5, 16'h9999, 8'h20, 1, 64'd0, "R10 clear with event fresh");
    step(1, 1, 3'd6, 16'hAAAA, 8'h00, 0, 64'd0, "R5 R3 uc replaces after fresh");
    step(1, 0, 3'd2, 16'hBBBB, 8'h04, 1, 64'd0, "R10 clear with event over uc");
    step(0, 0, 3'd0, 16'h0000, 8'h00, 1, 64'd0, "R9 clear again");
    step(1, 0, 3'd6, 16'hCCCC, 8'h00, 0, 64'd0, "R2 corrected disabled");
    step(1, 1, 3'd6, 16'hDDDD, 8'h40, 0, 64'd0, "R5 R8 uc enabled replaces");
    step(1, 0, 3'd6, 16'hEEEE, 8'h40, 0, 64'd0, "R7 R3 kept overflow held");
    step(0, 0, 3'd0, 16'h0000, 8'h00, 0, 64'd0, "R3 idle hold");
    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    finish_up();
  end
endmodule